// File: doc/BRIEF.md
# Peripheral Bus Request Framer

This block carries out the power controller's peripheral-bus command and its poll-off command. The host transport loads the command's argument bytes one at a time and then starts the command. The framer checks the arguments. A reserved leading byte pair turns the command into a write of the autopoll device mask. In every other case the framer repacks the arguments into a request for the attached serial peripheral bus, collects the answer, and leaves a framed reply in a small buffer that the interrupt-acknowledge path reads.

The peripheral bus is seen as two streams: a request stream with valid/ready handshaking and a response stream. Each reply is stored in one of two forms. A good non-empty answer is a status byte 0x01, then a length byte, then the data. A failed, empty or timed-out answer is the single byte 0x00. Either form raises the peripheral-bus interrupt flag. The flag stays set until it is acknowledged. Autopolling is reported as enabled only while no host command is in progress.

Top module: `pbus_req_framer`

## Requirements
- R1: A bus command (go_kind=0) with fewer than two argument bytes completes with `done`. It sends no request, raises no interrupt and leaves the autopoll registers unchanged.
- R2: When `bus_present` is low, a bus command completes with `done`. It sends no request, raises no interrupt and leaves the autopoll registers unchanged.
- R3: If argument bytes 0 and 1 are 0x00 and 0x86 and there are exactly four arguments, the command is an autopoll write. The mask is {arg2, arg3}, with arg2 as the upper byte. A nonzero mask is stored and sets `poll_en`. A zero mask clears `poll_en` and keeps the old mask. This form with any other argument count has no effect. An autopoll write never raises the interrupt.
- R4: Otherwise arg2 is the payload length. If there are fewer than three arguments, or the length exceeds (argument count − 3), or the length exceeds MAX_PAYLOAD, no request is sent. The reply becomes the single byte 0x00 (`reply_size`=1) and `int_flag` is set.
- R5: A valid command sends argument count − 2 request bytes: arg0 first, then arg3 onward in order. This holds even when the stated length is shorter. `req_last` marks the final byte.
- R6: A response of N>0 bytes (N ≤ RPL_DEPTH−2) is stored as 0x01 at read index 0, N at index 1 and the data from index 2. `reply_size` becomes N+2 and `int_flag` is set.
- R7: A response marked `rsp_none` produces the reply 0x00 with `reply_size`=1 and sets `int_flag`. So does a wait of TIMEOUT_CYC cycles without a response byte.
- R8: After reset, `int_flag` is 0 and `reply_size` is 0. `int_ack` clears both. A reply completing in the same cycle takes priority over the acknowledge.
- R9: The poll-off command (go_kind=1) with zero arguments and the bus present clears `poll_en`. With any arguments it has no effect.
- R10: `poll_active` is high exactly when `poll_en` is set and `host_busy` is low.
- R11: While `req_valid` is high and `req_ready` is low, `req_valid` and `req_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_present | input | 1 | Peripheral bus is fitted |
| host_busy | input | 1 | A host command is in progress |
| arg_wr | input | 1 | Append arg_data to the argument list (idle only) |
| arg_data | input | 8 | Argument byte |
| go | input | 1 | Start a command using the loaded arguments |
| go_kind | input | 1 | 0 bus command, 1 poll-off |
| busy | output | 1 | Command being processed |
| done | output | 1 | One-cycle pulse when a command completes |
| req_valid | output | 1 | Request byte valid |
| req_ready | input | 1 | Peripheral accepts request byte |
| req_data | output | 8 | Request byte |
| req_last | output | 1 | Final request byte |
| rsp_valid | input | 1 | Response byte or empty marker valid |
| rsp_ready | output | 1 | Framer waits for a response |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Final response byte |
| rsp_none | input | 1 | Peripheral answered with no data |
| rd_idx | input | $clog2(RPL_DEPTH) | Reply read index |
| rd_data | output | 8 | Reply byte at rd_idx |
| reply_size | output | $clog2(RPL_DEPTH+1) | Buffered reply size, 0 when none |
| int_flag | output | 1 | Peripheral-bus interrupt bit |
| int_ack | input | 1 | Acknowledge: clear the flag and the reply |
| poll_en | output | 1 | Autopoll enable register |
| poll_mask | output | 16 | Autopoll device mask |
| poll_active | output | 1 | Autopolling is running now |

## Verification
A corrupted argument count or send index shows on the request stream. The first wrong byte, or a `req_last` in the wrong place, appears within a few cycles of `go`. A lost reply count or header register shows the next time the reply buffer is read after `done`. A stuck interrupt or size register breaks the lockstep between `int_flag` and a nonzero `reply_size` on the very next clock edge. A wrongly written autopoll register shows on `poll_en` and `poll_mask` in the cycle `done` is raised.

// File: rtl/pbf_pkg.sv
package pbf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_SEND, ST_WAIT} pbf_state_e;
  localparam logic       KIND_BUSCMD  = 1'b0;
  localparam logic       KIND_POLLOFF = 1'b1;
  localparam logic [7:0] AP_TAG0      = 8'h00;
  localparam logic [7:0] AP_TAG1      = 8'h86;
  localparam logic [7:0] STAT_OK      = 8'h01;
  localparam logic [7:0] STAT_FAIL    = 8'h00;
endpackage

// File: rtl/pbf_arg_store.sv
module pbf_arg_store #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          clr,
  output logic [CW-1:0] cnt_o,
  output logic [7:0]    data_o [DEPTH]
);
  logic [CW-1:0] cnt_q;
  logic [7:0]    mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt_q <= '0;
    else if (clr)                              cnt_q <= '0;
    else if (wr_en && (cnt_q < CW'(DEPTH)))    cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && !clr && (cnt_q == CW'(g))) mem_q[g] <= wr_data;
    end
  end

  assign cnt_o  = cnt_q;
  assign data_o = mem_q;
endmodule

// File: rtl/pbf_reply_buf.sv
module pbf_reply_buf #(
  parameter int DEPTH = 14,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(g))) mem_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < DEPTH; i++) begin
      if (raddr == AW'(i)) rdata = mem_q[i];
    end
  end
endmodule

// File: rtl/pbf_timeout.sv
module pbf_timeout #(
  parameter int LIMIT = 32,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  logic [CW-1:0] cnt_q;

  assign expired = run && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (run && !expired)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pbus_req_framer.sv
module pbus_req_framer
  import pbf_pkg::*;
#(
  parameter  int ARG_DEPTH   = 16,
  parameter  int RPL_DEPTH   = 16,
  parameter  int MAX_PAYLOAD = 252,
  parameter  int TIMEOUT_CYC = 32,
  localparam int RIW         = $clog2(RPL_DEPTH),
  localparam int SW          = $clog2(RPL_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_present,
  input  logic           host_busy,
  input  logic           arg_wr,
  input  logic [7:0]     arg_data,
  input  logic           go,
  input  logic           go_kind,
  output logic           busy,
  output logic           done,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [7:0]     req_data,
  output logic           req_last,
  input  logic           rsp_valid,
  output logic           rsp_ready,
  input  logic [7:0]     rsp_data,
  input  logic           rsp_last,
  input  logic           rsp_none,
  input  logic [RIW-1:0] rd_idx,
  output logic [7:0]     rd_data,
  output logic [SW-1:0]  reply_size,
  output logic           int_flag,
  input  logic           int_ack,
  output logic           poll_en,
  output logic [15:0]    poll_mask,
  output logic           poll_active
);
  localparam int ACW = $clog2(ARG_DEPTH + 1);
  localparam int AIW = $clog2(ARG_DEPTH);
  localparam int CAP = RPL_DEPTH - 2;
  localparam int PW  = $clog2(CAP);

  // argument storage
  logic [ACW-1:0] arg_cnt;
  logic [7:0]     args [ARG_DEPTH];
  logic           arg_clr;
  logic           arg_we;

  // registers and their next values
  pbf_state_e     state_q, state_n;
  logic [ACW-1:0] argc_q, argc_n;
  logic           kind_q, kind_n;
  logic [ACW-1:0] idx_q, idx_n;
  logic [SW-1:0]  rcnt_q, rcnt_n;
  logic [7:0]     stat_q, stat_n;
  logic [SW-1:0]  lenb_q, lenb_n;
  logic [SW-1:0]  size_q, size_n;
  logic           int_q, int_n;
  logic           done_q, done_n;
  logic           pen_q, pen_n;
  logic [15:0]    pmask_q, pmask_n;

  // reply payload store and timer hooks
  logic           buf_we;
  logic [PW-1:0]  buf_waddr;
  logic [PW-1:0]  buf_raddr;
  logic [7:0]     buf_rdata;
  logic           tmr_clr, tmr_run, tmr_exp;

  // finish request from the check or wait phase
  logic           fin;
  logic [SW-1:0]  fin_cnt;

  // argument decode
  logic [7:0]     a0, a1, a2, a3;
  logic [8:0]     avail;
  logic           len_bad;
  logic           is_autopoll;
  logic [ACW-1:0] send_src;
  logic [15:0]    ap_mask;

  assign arg_we  = arg_wr && (state_q == ST_IDLE);
  assign arg_clr = go && (state_q == ST_IDLE);

  pbf_arg_store #(.DEPTH(ARG_DEPTH), .CW(ACW)) i_args (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (arg_we),
    .wr_data (arg_data),
    .clr     (arg_clr),
    .cnt_o   (arg_cnt),
    .data_o  (args)
  );

  pbf_reply_buf #(.DEPTH(CAP), .AW(PW)) i_reply (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (rsp_data),
    .raddr (buf_raddr),
    .rdata (buf_rdata)
  );

  pbf_timeout #(.LIMIT(TIMEOUT_CYC)) i_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .run     (tmr_run),
    .expired (tmr_exp)
  );

  assign a0          = args[0];
  assign a1          = args[1];
  assign a2          = args[2];
  assign a3          = args[3];
  assign ap_mask     = {a2, a3};
  assign avail       = 9'(argc_q) - 9'd3;
  assign is_autopoll = (a0 == AP_TAG0) && (a1 == AP_TAG1);
  assign len_bad     = (argc_q < ACW'(3)) || ({1'b0, a2} > avail) ||
                       (32'(a2) > MAX_PAYLOAD);
  assign send_src    = idx_q + ACW'(2);

  // request stream
  assign req_valid = (state_q == ST_SEND);
  assign req_data  = (idx_q == '0) ? a0 : args[send_src[AIW-1:0]];
  assign req_last  = (idx_q == (argc_q - ACW'(3)));
  assign rsp_ready = (state_q == ST_WAIT);
  assign tmr_run   = (state_q == ST_WAIT);
  assign buf_waddr = rcnt_q[PW-1:0];

  always_comb begin
    state_n = state_q;
    argc_n  = argc_q;
    kind_n  = kind_q;
    idx_n   = idx_q;
    rcnt_n  = rcnt_q;
    stat_n  = stat_q;
    lenb_n  = lenb_q;
    size_n  = size_q;
    int_n   = int_q;
    done_n  = 1'b0;
    pen_n   = pen_q;
    pmask_n = pmask_q;
    buf_we  = 1'b0;
    tmr_clr = 1'b0;
    fin     = 1'b0;
    fin_cnt = '0;

    if (int_ack) begin
      int_n  = 1'b0;
      size_n = '0;
    end

    case (state_q)
      ST_IDLE: begin
        if (go) begin
          argc_n  = arg_cnt;
          kind_n  = go_kind;
          state_n = ST_CHECK;
        end
      end
      ST_CHECK: begin
        state_n = ST_IDLE;
        done_n  = 1'b1;
        if (kind_q == KIND_POLLOFF) begin
          if ((argc_q == '0) && bus_present) pen_n = 1'b0;
        end else if ((argc_q < ACW'(2)) || !bus_present) begin
          // nothing to do
        end else if (is_autopoll) begin
          if (argc_q == ACW'(4)) begin
            if (ap_mask != '0) begin
              pmask_n = ap_mask;
              pen_n   = 1'b1;
            end else begin
              pen_n   = 1'b0;
            end
          end
        end else if (len_bad) begin
          fin = 1'b1;
        end else begin
          idx_n   = '0;
          state_n = ST_SEND;
          done_n  = 1'b0;
        end
      end
      ST_SEND: begin
        if (req_ready) begin
          if (req_last) begin
            state_n = ST_WAIT;
            rcnt_n  = '0;
            tmr_clr = 1'b1;
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          tmr_clr = 1'b1;
          if (rsp_none) begin
            fin = 1'b1;
          end else begin
            if (rcnt_q < SW'(CAP)) begin
              buf_we = 1'b1;
              rcnt_n = rcnt_q + 1'b1;
            end
            if (rsp_last) begin
              fin     = 1'b1;
              fin_cnt = rcnt_n;
            end
          end
        end else if (tmr_exp) begin
          fin = 1'b1;
        end
        if (fin) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase

    if (fin) begin
      int_n = 1'b1;
      if (fin_cnt != '0) begin
        stat_n = STAT_OK;
        lenb_n = fin_cnt;
        size_n = fin_cnt + SW'(2);
      end else begin
        stat_n = STAT_FAIL;
        lenb_n = '0;
        size_n = SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      argc_q  <= '0;
      kind_q  <= KIND_BUSCMD;
      idx_q   <= '0;
      rcnt_q  <= '0;
      stat_q  <= STAT_FAIL;
      lenb_q  <= '0;
      size_q  <= '0;
      int_q   <= 1'b0;
      done_q  <= 1'b0;
      pen_q   <= 1'b0;
      pmask_q <= '0;
    end else begin
      state_q <= state_n;
      argc_q  <= argc_n;
      kind_q  <= kind_n;
      idx_q   <= idx_n;
      rcnt_q  <= rcnt_n;
      stat_q  <= stat_n;
      lenb_q  <= lenb_n;
      size_q  <= size_n;
      int_q   <= int_n;
      done_q  <= done_n;
      pen_q   <= pen_n;
      pmask_q <= pmask_n;
    end
  end

  // reply read port: header bytes in registers, payload in the buffer
  assign buf_raddr = PW'(rd_idx - RIW'(2));
  always_comb begin
    if (rd_idx == '0)          rd_data = stat_q;
    else if (rd_idx == RIW'(1)) rd_data = 8'(lenb_q);
    else                       rd_data = buf_rdata;
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign reply_size  = size_q;
  assign int_flag    = int_q;
  assign poll_en     = pen_q;
  assign poll_mask   = pmask_q;
  assign poll_active = pen_q && !host_busy;
endmodule

// File: rtl/pbf_checker.sv
module pbf_checker #(
  parameter int SW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          req_valid,
  input logic          req_ready,
  input logic [7:0]    req_data,
  input logic          rsp_ready,
  input logic [SW-1:0] reply_size,
  input logic          int_flag,
  input logic          int_ack,
  input logic          poll_en,
  input logic [15:0]   poll_mask
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_data)); // R11
  AST_NO_STREAM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !rsp_ready); // R5
  AST_ENABLE_MASK_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    poll_en |-> poll_mask != 16'h0000); // R3
  AST_REPLY_SIZE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flag) |-> (reply_size == SW'(1)) || (reply_size >= SW'(3))); // R6
  AST_FLAG_SIZE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    int_flag == (reply_size != '0)); // R8
  AST_FLAG_FALL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_flag) |-> $past(int_ack)); // R8
endmodule

bind pbus_req_framer pbf_checker #(.SW(SW)) i_pbf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_data   (req_data),
  .rsp_ready  (rsp_ready),
  .reply_size (reply_size),
  .int_flag   (int_flag),
  .int_ack    (int_ack),
  .poll_en    (poll_en),
  .poll_mask  (poll_mask)
);

// File: tb/test_pbus_req_framer.sv
module test_pbus_req_framer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_present = 1'b1, host_busy = 1'b0;
  logic        arg_wr = 1'b0, go = 1'b0, go_kind = 1'b0;
  logic [7:0]  arg_data = 8'h00;
  logic        busy, done, req_valid, req_last, rsp_ready;
  logic        req_ready = 1'b0;
  logic [7:0]  req_data, rd_data;
  logic        rsp_valid = 1'b0, rsp_last = 1'b0, rsp_none = 1'b0;
  logic [7:0]  rsp_data = 8'h00;
  logic [3:0]  rd_idx = 4'd0;
  logic [4:0]  reply_size;
  logic        int_flag, poll_en, poll_active;
  logic        int_ack = 1'b0;
  logic [15:0] poll_mask;

  int checks = 0, errors = 0;

  logic [7:0] arg_q [16];
  int         arg_n;
  logic [7:0] rsp_b [16];
  int         rsp_n, rsp_mode;
  logic [7:0] req_cap [16];
  int         req_cnt, last_pos, hold_err, run_cyc;
  logic       saw_done;

  always #10 clk = ~clk;

  pbus_req_framer i_pbus_req_framer (
    .clk(clk), .rst_n(rst_n), .bus_present(bus_present), .host_busy(host_busy),
    .arg_wr(arg_wr), .arg_data(arg_data), .go(go), .go_kind(go_kind),
    .busy(busy), .done(done), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .req_last(req_last), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .rsp_none(rsp_none), .rd_idx(rd_idx), .rd_data(rd_data),
    .reply_size(reply_size), .int_flag(int_flag), .int_ack(int_ack),
    .poll_en(poll_en), .poll_mask(poll_mask), .poll_active(poll_active)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic kind);
    int rp;
    logic prev_hold;
    logic [7:0] prev_data;
    rp = 0; prev_hold = 1'b0; prev_data = 8'h00;
    req_cnt = 0; last_pos = -1; hold_err = 0; saw_done = 1'b0; run_cyc = 0;
    for (int i = 0; i < arg_n; i++) begin
      @(negedge clk); arg_wr = 1'b1; arg_data = arg_q[i];
    end
    @(negedge clk); arg_wr = 1'b0; go = 1'b1; go_kind = kind;
    @(negedge clk); go = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (k > 0) @(negedge clk);
      run_cyc++;
      if (done) begin saw_done = 1'b1; break; end
      if (prev_hold && (!req_valid || req_data !== prev_data)) hold_err++;
      if (req_valid) begin
        req_ready = (k % 3) != 1;
        prev_hold = !req_ready;
        prev_data = req_data;
        if (req_ready) begin
          req_cap[req_cnt] = req_data;
          if (req_last) last_pos = req_cnt;
          req_cnt++;
        end
      end else begin
        req_ready = 1'b0;
        prev_hold = 1'b0;
      end
      rsp_valid = 1'b0; rsp_last = 1'b0; rsp_none = 1'b0;
      if (rsp_ready) begin
        if (rsp_mode == 0 && rp < rsp_n) begin
          rsp_valid = 1'b1; rsp_data = rsp_b[rp]; rsp_last = (rp == rsp_n - 1); rp++;
        end else if (rsp_mode == 1 && rp == 0) begin
          rsp_valid = 1'b1; rsp_none = 1'b1; rp++;
        end
      end
    end
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_last = 1'b0; rsp_none = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_chk(input string req, input int idx, input logic [7:0] exp);
    rd_idx = 4'(idx);
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic ack_int();
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R8 reset int_flag", int_flag, 0);
    check("R8 reset reply_size", reply_size, 0);
    check("R3 reset poll_en", poll_en, 0);
    check("R5 reset req_valid", req_valid, 0);
  endtask

  task automatic t_short();  // R1
    arg_q[0] = 8'h2C; arg_n = 1; rsp_mode = 0; rsp_n = 0;
    run_cmd(1'b0);
    check("R1 done", saw_done, 1);
    check("R1 no request", req_cnt, 0);
    check("R1 no int", int_flag, 0);
  endtask

  task automatic t_nobus();  // R2
    bus_present = 1'b0;
    arg_q[0] = 8'h2C; arg_q[1] = 8'h00; arg_q[2] = 8'h01; arg_q[3] = 8'h11; arg_n = 4;
    run_cmd(1'b0);
    check("R2 done", saw_done, 1);
    check("R2 no request", req_cnt, 0);
    check("R2 no int", int_flag, 0);
    arg_q[0] = 8'h00; arg_q[1] = 8'h86; arg_q[2] = 8'h12; arg_q[3] = 8'h34;
    run_cmd(1'b0);
    check("R2 autopoll untouched", poll_en, 0);
    bus_present = 1'b1;
  endtask

  task automatic t_autopoll();  // R3
    arg_q[0] = 8'h00; arg_q[1] = 8'h86; arg_q[2] = 8'h12; arg_q[3] = 8'h34; arg_n = 4;
    run_cmd(1'b0);
    check("R3 enable set", poll_en, 1);
    check("R3 mask big-endian", poll_mask, 16'h1234);
    check("R3 no int", int_flag, 0);
    arg_q[2] = 8'h00; arg_n = 3;
    run_cmd(1'b0);
    check("R3 wrong count ignored en", poll_en, 1);
    check("R3 wrong count ignored mask", poll_mask, 16'h1234);
    check("R3 wrong count no request", req_cnt, 0);
    arg_q[2] = 8'h00; arg_q[3] = 8'h00; arg_n = 4;
    run_cmd(1'b0);
    check("R3 zero mask disables", poll_en, 0);
    check("R3 zero mask keeps mask", poll_mask, 16'h1234);
  endtask

  task automatic t_len_fail();  // R4
    arg_q[0] = 8'h2C; arg_q[1] = 8'h00; arg_q[2] = 8'h03; arg_q[3] = 8'hAA; arg_q[4] = 8'hBB;
    arg_n = 5;
    run_cmd(1'b0);
    check("R4 no request", req_cnt, 0);
    check("R4 int set", int_flag, 1);
    check("R4 size", reply_size, 1);
    read_chk("R4 fail byte", 0, 8'h00);
    ack_int();
    arg_n = 2;
    run_cmd(1'b0);
    check("R4 two args no request", req_cnt, 0);
    check("R4 two args size", reply_size, 1);
    ack_int();
  endtask

  task automatic t_request();  // R5 R6 R11
    arg_q[0] = 8'h2C; arg_q[1] = 8'h00; arg_q[2] = 8'h02; arg_q[3] = 8'hAA; arg_q[4] = 8'hBB;
    arg_n = 5; rsp_mode = 0; rsp_n = 3;
    rsp_b[0] = 8'h11; rsp_b[1] = 8'h22; rsp_b[2] = 8'h33;
    run_cmd(1'b0);
    check("R5 request count", req_cnt, 3);
    check("R5 byte0", req_cap[0], 8'h2C);
    check("R5 byte1", req_cap[1], 8'hAA);
    check("R5 byte2", req_cap[2], 8'hBB);
    check("R5 last position", last_pos, 2);
    check("R11 held under stall", hold_err, 0);
    check("R6 int set", int_flag, 1);
    check("R6 size", reply_size, 5);
    read_chk("R6 status", 0, 8'h01);
    read_chk("R6 length", 1, 8'h03);
    read_chk("R6 data0", 2, 8'h11);
    read_chk("R6 data2", 4, 8'h33);
    ack_int();
  endtask

  task automatic t_extra();  // R5
    arg_q[0] = 8'h3C; arg_q[1] = 8'h00; arg_q[2] = 8'h01; arg_q[3] = 8'h55; arg_q[4] = 8'h66;
    arg_n = 5; rsp_mode = 0; rsp_n = 1; rsp_b[0] = 8'h77;
    run_cmd(1'b0);
    check("R5 extra args sent", req_cnt, 3);
    check("R5 extra tail byte", req_cap[2], 8'h66);
    check("R6 single byte size", reply_size, 3);
    ack_int();
  endtask

  task automatic t_empty();  // R7
    arg_q[0] = 8'h2C; arg_q[1] = 8'h00; arg_q[2] = 8'h00; arg_n = 3; rsp_mode = 1;
    run_cmd(1'b0);
    check("R7 empty int", int_flag, 1);
    check("R7 empty size", reply_size, 1);
    read_chk("R7 empty byte", 0, 8'h00);
    ack_int();
    rsp_mode = 2;
    run_cmd(1'b0);
    check("R7 timeout done", saw_done, 1);
    check("R7 timeout waited", run_cyc > 32, 1);
    check("R7 timeout size", reply_size, 1);
    read_chk("R7 timeout byte", 0, 8'h00);
  endtask

  task automatic t_ack();  // R8
    check("R8 flag before ack", int_flag, 1);
    ack_int();
    check("R8 ack clears flag", int_flag, 0);
    check("R8 ack clears size", reply_size, 0);
  endtask

  task automatic t_polloff();  // R9 R10
    arg_q[0] = 8'h00; arg_q[1] = 8'h86; arg_q[2] = 8'h00; arg_q[3] = 8'h05; arg_n = 4; rsp_mode = 0;
    run_cmd(1'b0);
    check("R10 active when idle", poll_active, 1);
    host_busy = 1'b1; #1;
    check("R10 inactive while host busy", poll_active, 0);
    host_busy = 1'b0; #1;
    check("R10 active again", poll_active, 1);
    arg_q[0] = 8'h01; arg_n = 1;
    run_cmd(1'b1);
    check("R9 poll-off with args ignored", poll_en, 1);
    arg_n = 0;
    run_cmd(1'b1);
    check("R9 poll-off disables", poll_en, 0);
    check("R9 poll-off no int", int_flag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_nobus();
    t_autopoll();
    t_len_fail();
    t_request();
    t_extra();
    t_empty();
    t_ack();
    t_polloff();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule